// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block drives an external single-slope converter that has a multiplexed input. Digitising one channel takes two steps. The block first puts the channel code on a 3-bit mux address and holds the ramp-start output low. During that acquisition window the selected voltage charges the ramp capacitor. The block then raises ramp-start and counts system clocks until the open-collector comparator output (ramp-stop) falls. The count, the channel and a timeout flag are returned with a single-cycle valid strobe.

Code 000 on the mux is ground and code 111 is the reference voltage. Codes 001 to 110 select the six external inputs. In auto-calibrate mode, each user conversion is preceded by a conversion of 000 and then a conversion of 111. Any successful conversion of either calibration code is latched into a zero-count or full-count register, where a separate correction block can read it. Ramp-stop is resynchronised by a two-flop chain. A falling edge is only honoured while the ramp is running. A programmable ceiling ends a conversion whose comparator never trips.

Top module: `slope_adc_seq`

## Requirements
- R1: After reset, ramp_start, busy and result_valid are 0, mux_addr is 000, and zero_count and full_count are 0.
- R2: conv_req is taken only when busy is 0. A request raised while busy neither starts a conversion nor changes the one in progress.
- R3: Each conversion begins with an acquisition phase. In this phase busy is 1 and ramp_start is 0 for exactly acq_cycles clock cycles, and mux_addr holds steady. After that, ramp_start rises.
- R4: On a completed conversion, result_count is one less than the number of clock cycles for which ramp_start was high during that conversion. Ramp-stop passes through two synchroniser flops before the falling edge is taken.
- R5: result_valid is a one-cycle pulse. ramp_start is 0 in the same cycle as result_valid, and busy is 0 in that cycle unless another step follows.
- R6: A low level or falling edge on ramp_stop during the acquisition phase is ignored. It does not change the result.
- R7: If the count reaches max_count without a falling edge, the conversion ends with result_timeout=1 and result_count=max_count, and the remaining steps are dropped. A falling edge taken on the cycle the count equals max_count is a normal result.
- R8: With auto_cal=1, the steps run in this order: code 000, code 111, then the requested code. Each step has its own acquisition phase. result_valid fires only for the last step, or for a step that timed out, and result_chan carries the code converted.
- R9: zero_count takes the count of every completed, non-timed-out conversion of code 000. full_count does the same for code 111. A timed-out conversion leaves both registers unchanged.
- R10: mux_addr carries the 3-bit code of the step being converted. When the user step runs, that is the requested conv_chan, for any value 000 to 111.
- R11: acq_cycles equal to 0 selects the parameter ACQ_DEFAULT as the acquisition length (default 8000 cycles, which is 40 us at 200 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Request a conversion (taken when idle) |
| conv_chan | input | 3 | Requested mux code |
| auto_cal | input | 1 | Run the zero and full-scale steps first |
| acq_cycles | input | ACQ_W | Acquisition length in cycles; 0 selects ACQ_DEFAULT |
| max_count | input | CNT_W | Ramp count ceiling before timeout |
| mux_addr | output | 3 | Address driven to the analog multiplexer |
| ramp_start | output | 1 | High while the ramp runs |
| ramp_stop | input | 1 | Comparator output, asynchronous, pulled up |
| busy | output | 1 | A sequence is in progress |
| result_valid | output | 1 | One-cycle strobe for a result |
| result_count | output | CNT_W | Measured ramp count |
| result_chan | output | 3 | Code that produced the result |
| result_timeout | output | 1 | Result ended on the ceiling |
| zero_count | output | CNT_W | Latest ground-code count |
| full_count | output | CNT_W | Latest reference-code count |

## Verification
The bench aims at the edges of the count window. It places a comparator trip exactly on the ceiling and one cycle past it. A design that compares in the wrong order either reports a false timeout or returns max_count+1. It pulses ramp_stop low mid-acquisition and raises a request while busy. A design that does not gate the edge detector by phase would return a tiny count, and one that takes the stray request would rewrite the address or emit an extra strobe. Auto-calibrate runs, including one whose ground step times out, expose a wrong step order, strobes for the calibration steps, or calibration registers overwritten by a failed measurement.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_RAMP = 2'd2
  } seq_state_t;

  localparam logic [2:0] CODE_GND = 3'b000;
  localparam logic [2:0] CODE_REF = 3'b111;

  // acquisition ends once the elapsed count reaches the effective length
  function automatic logic acq_finished(input logic [31:0] elapsed,
                                        input logic [31:0] len,
                                        input logic [31:0] len_default);
    logic [31:0] eff;
    eff = (len == 32'd0) ? len_default : len;
    return (elapsed + 32'd1) >= eff;
  endfunction

  // channel converted at a given step of a sequence
  function automatic logic [2:0] step_code(input logic cal,
                                           input logic [1:0] idx,
                                           input logic [2:0] user);
    if (!cal) return user;
    case (idx)
      2'd0:    return CODE_GND;
      2'd1:    return CODE_REF;
      default: return user;
    endcase
  endfunction

  function automatic logic is_final_step(input logic cal, input logic [1:0] idx);
    return cal ? (idx == 2'd2) : 1'b1;
  endfunction

endpackage

// File: rtl/stop_edge_sync.sv
module stop_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_async,
  output logic stop_fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= stop_async;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  // last synchronised stage low while the delayed copy is still high
  assign stop_fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (en)  count <= count + 1'b1;
  end
endmodule

// File: rtl/slope_adc_seq.sv
module slope_adc_seq
  import slope_adc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ACQ_W       = 16,
  parameter int ACQ_DEFAULT = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic [2:0]       conv_chan,
  input  logic             auto_cal,
  input  logic [ACQ_W-1:0] acq_cycles,
  input  logic [CNT_W-1:0] max_count,
  output logic [2:0]       mux_addr,
  output logic             ramp_start,
  input  logic             ramp_stop,
  output logic             busy,
  output logic             result_valid,
  output logic [CNT_W-1:0] result_count,
  output logic [2:0]       result_chan,
  output logic             result_timeout,
  output logic [CNT_W-1:0] zero_count,
  output logic [CNT_W-1:0] full_count
);
  seq_state_t       state;
  logic [1:0]       step_idx;
  logic [2:0]       user_chan;
  logic             cal_q;
  logic [ACQ_W-1:0] acq_cnt;
  logic [CNT_W-1:0] ramp_cnt;

  // named events shared by the datapath and the assertions
  logic stop_fall, accept, acq_done, stop_taken, timed_out, conv_end, last_step;

  stop_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .stop_async(ramp_stop), .stop_fall(stop_fall)
  );

  assign accept     = (state == ST_IDLE) && conv_req;
  assign acq_done   = (state == ST_ACQ) &&
                      acq_finished(32'(acq_cnt), 32'(acq_cycles), 32'(ACQ_DEFAULT));
  assign stop_taken = (state == ST_RAMP) && stop_fall;
  assign timed_out  = (state == ST_RAMP) && !stop_fall && (ramp_cnt == max_count);
  assign conv_end   = stop_taken || timed_out;
  assign last_step  = is_final_step(cal_q, step_idx);
  assign busy       = (state != ST_IDLE);

  cycle_counter #(.W(ACQ_W)) u_acq_cnt (
    .clk(clk), .rst_n(rst_n), .clr(accept || conv_end),
    .en(state == ST_ACQ), .count(acq_cnt)
  );

  cycle_counter #(.W(CNT_W)) u_ramp_cnt (
    .clk(clk), .rst_n(rst_n), .clr(acq_done),
    .en(state == ST_RAMP), .count(ramp_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step_idx   <= 2'd0;
      user_chan  <= 3'd0;
      cal_q      <= 1'b0;
      mux_addr   <= 3'd0;
      ramp_start <= 1'b0;
    end else begin
      if (accept) begin
        state     <= ST_ACQ;
        step_idx  <= 2'd0;
        user_chan <= conv_chan;
        cal_q     <= auto_cal;
        mux_addr  <= step_code(auto_cal, 2'd0, conv_chan);
      end else if (acq_done) begin
        state      <= ST_RAMP;
        ramp_start <= 1'b1;
      end else if (conv_end) begin
        ramp_start <= 1'b0;
        if (timed_out || last_step) begin
          state <= ST_IDLE;
        end else begin
          state    <= ST_ACQ;
          step_idx <= 2'(step_idx + 2'd1);
          mux_addr <= step_code(cal_q, 2'(step_idx + 2'd1), user_chan);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid   <= 1'b0;
      result_count   <= '0;
      result_chan    <= 3'd0;
      result_timeout <= 1'b0;
      zero_count     <= '0;
      full_count     <= '0;
    end else begin
      result_valid <= conv_end && (timed_out || last_step);
      if (conv_end) begin
        result_count   <= ramp_cnt;
        result_chan    <= mux_addr;
        result_timeout <= timed_out;
      end
      if (stop_taken && mux_addr == CODE_GND) zero_count <= ramp_cnt;
      if (stop_taken && mux_addr == CODE_REF) full_count <= ramp_cnt;
    end
  end

  // ---------------- assertions ----------------
  p_user_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_end) |=> $stable(user_chan));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && $past(state) == ST_ACQ) |-> $stable(mux_addr));

  p_rise_from_acq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_start) |-> $past(state) == ST_ACQ);

  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_start_low_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !ramp_start);

  p_no_edge_in_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ) |=> (ramp_cnt == '0 || state != ST_RAMP));

  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_timeout) |-> result_count == max_count);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP) |-> ramp_cnt <= max_count);
endmodule

// File: tb/slope_adc_seq_tb.sv
module slope_adc_seq_tb_top;
  localparam int CW = 16;
  localparam int AW = 16;
  localparam int ADEF = 8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_req = 1'b0;
  logic [2:0] conv_chan = 3'd0;
  logic auto_cal = 1'b0;
  logic [AW-1:0] acq_cycles = '0;
  logic [CW-1:0] max_count = '0;
  logic [2:0] mux_addr;
  logic ramp_start;
  logic ramp_stop = 1'b1;
  logic busy, result_valid, result_timeout;
  logic [CW-1:0] result_count, zero_count, full_count;
  logic [2:0] result_chan;

  always #2.5 clk = ~clk;

  slope_adc_seq #(.CNT_W(CW), .ACQ_W(AW), .ACQ_DEFAULT(ADEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_chan(conv_chan),
    .auto_cal(auto_cal), .acq_cycles(acq_cycles), .max_count(max_count),
    .mux_addr(mux_addr), .ramp_start(ramp_start), .ramp_stop(ramp_stop),
    .busy(busy), .result_valid(result_valid), .result_count(result_count),
    .result_chan(result_chan), .result_timeout(result_timeout),
    .zero_count(zero_count), .full_count(full_count)
  );

  typedef struct { int cyc; int cnt; int ch; bit to; } res_t;
  typedef struct { int cyc; int ch; } rise_t;
  typedef struct { int cyc; bit full; int val; } cal_t;
  res_t  rq[$];
  rise_t aq[$];
  cal_t  cq[$];

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int delay[8];
  int glitch_lo = -1, glitch_hi = -1;
  int cur_acq = 1;
  int exp_zero = 0, exp_full = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // comparator model: low D negedges after ramp start rises, high while start low
  int ramp_n = 0;
  always @(negedge clk) begin
    if (!ramp_start) begin
      ramp_n = 0;
      ramp_stop <= !(cyc >= glitch_lo && cyc < glitch_hi);
    end else begin
      ramp_n = ramp_n + 1;
      if (ramp_n >= delay[mux_addr]) ramp_stop <= 1'b0;
    end
  end

  // per-clock reference comparison
  bit prev_start = 1'b0;
  int hi_len = 0, lo_len = 0;
  logic [2:0] acq_addr = 3'd0;
  always @(negedge clk) begin
    if (checking) begin
      while (cq.size() > 0 && cq[0].cyc == cyc) begin
        if (cq[0].full) exp_full = cq[0].val; else exp_zero = cq[0].val;
        void'(cq.pop_front());
      end
      chk(zero_count == CW'(exp_zero), "R9 zero_count", int'(zero_count), exp_zero);
      chk(full_count == CW'(exp_full), "R9 full_count", int'(full_count), exp_full);
      if (ramp_start) hi_len = prev_start ? hi_len + 1 : 1;
      if (rq.size() > 0 && rq[0].cyc == cyc) begin
        chk(result_valid, "R8 strobe time", int'(result_valid), 1);
        chk(result_count == CW'(rq[0].cnt), "R7 count", int'(result_count), rq[0].cnt);
        chk(int'(result_chan) == rq[0].ch, "R8 chan", int'(result_chan), rq[0].ch);
        chk(result_timeout == rq[0].to, "R7 timeout flag", int'(result_timeout), int'(rq[0].to));
        chk(int'(result_count) == hi_len - 1, "R4 ramp width", int'(result_count), hi_len - 1);
        chk(!ramp_start, "R5 start low", int'(ramp_start), 0);
        void'(rq.pop_front());
      end else begin
        chk(!result_valid, "R5 no stray strobe", int'(result_valid), 0);
      end
      if (ramp_start && !prev_start) begin
        chk(aq.size() > 0 && aq[0].cyc == cyc, "R3 rise time", cyc, aq.size() > 0 ? aq[0].cyc : -1);
        chk(aq.size() > 0 && int'(mux_addr) == aq[0].ch, "R10 addr", int'(mux_addr),
            aq.size() > 0 ? aq[0].ch : -1);
        chk(lo_len == cur_acq, "R3 acq length", lo_len, cur_acq);
        if (aq.size() > 0) void'(aq.pop_front());
      end
      if (busy && !ramp_start) begin
        if (lo_len == 0) acq_addr = mux_addr;
        else chk(mux_addr == acq_addr, "R3 addr stable", int'(mux_addr), int'(acq_addr));
        lo_len = lo_len + 1;
      end
      if (ramp_start) lo_len = 0;
      prev_start = ramp_start;
    end
    if (cyc > 150000 && !done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog cyc=%0d actual=0 expected=1", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic do_req(input int ch, input bit cal, input int a, input int m, input bit glitch);
    int t, ea, n, c;
    @(negedge clk);
    t = cyc + 1;
    conv_req = 1'b1; conv_chan = 3'(ch); auto_cal = cal;
    acq_cycles = AW'(a); max_count = CW'(m);
    ea = (a == 0) ? ADEF : a;
    cur_acq = ea;
    if (glitch) begin glitch_lo = t + 3; glitch_hi = t + 6; end
    n = cal ? 3 : 1;
    for (int s = 0; s < n; s++) begin
      c = !cal ? ch : (s == 0 ? 0 : (s == 1 ? 7 : ch));
      aq.push_back('{t + ea, c});
      if (delay[c] + 1 <= m) begin
        t = t + ea + delay[c] + 2;
        if (c == 0) cq.push_back('{t, 1'b0, delay[c] + 1});
        if (c == 7) cq.push_back('{t, 1'b1, delay[c] + 1});
        if (s == n - 1) rq.push_back('{t, delay[c] + 1, c, 1'b0});
      end else begin
        t = t + ea + m + 1;
        rq.push_back('{t, m, c, 1'b1});
        break;
      end
    end
    @(negedge clk);
    conv_req = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (rq.size() > 0 || busy);
    repeat (4) @(negedge clk);
    glitch_lo = -1; glitch_hi = -1;
  endtask

  initial begin
    delay[0] = 3;  delay[1] = 12; delay[2] = 30; delay[3] = 10;
    delay[4] = 7;  delay[5] = 15; delay[6] = 20; delay[7] = 60;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!ramp_start, "R1 ramp_start", int'(ramp_start), 0);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!result_valid, "R1 valid", int'(result_valid), 0);
    chk(mux_addr == 3'd0, "R1 addr", int'(mux_addr), 0);
    chk(zero_count == '0 && full_count == '0, "R1 cal regs", int'(zero_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    checking = 1'b1;

    do_req(3, 1'b0, 8, 1000, 1'b0); wait_done();   // R4 plain input
    do_req(0, 1'b0, 4, 1000, 1'b0); wait_done();   // R9 ground direct
    do_req(7, 1'b0, 4, 1000, 1'b0); wait_done();   // R9 reference direct
    delay[0] = 6; delay[7] = 40;
    do_req(2, 1'b1, 6, 1000, 1'b0); wait_done();   // R8 auto-calibrate order
    do_req(5, 1'b0, 20, 1000, 1'b1); wait_done();  // R6 glitch in acquisition
    do_req(1, 1'b0, 5, 13, 1'b0); wait_done();     // R7 trip exactly on ceiling
    do_req(1, 1'b0, 5, 12, 1'b0); wait_done();     // R7 one past ceiling
    do_req(6, 1'b0, 0, 1000, 1'b0); wait_done();   // R11 default acquisition

    // R2 request while busy is ignored
    do_req(4, 1'b0, 10, 1000, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy, "R2 busy before poke", int'(busy), 1);
    conv_req = 1'b1; conv_chan = 3'd6; auto_cal = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    chk(mux_addr == 3'd4, "R2 addr unchanged", int'(mux_addr), 4);
    wait_done();
    chk(!busy, "R2 idle after", int'(busy), 0);

    // R7 and R9: timeout on the ground step of a calibrated run
    delay[0] = 500;
    do_req(3, 1'b1, 6, 100, 1'b0); wait_done();
    delay[0] = 5;
    do_req(6, 1'b1, 3, 1000, 1'b0); wait_done();   // R8 R10 second calibrated run

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule